// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the software-visible face of a block-based hash engine. A 32-bit CPU bus reaches four regions through it: a control and status word, a message byte counter, a 32-byte window onto the eight chaining-state words, and a 64-byte data window. Message words written to the data window are gathered into 512-bit blocks. Each full block is handed to an external compression core through a start/done handshake, together with the current chaining state. The core returns the updated state, which the front-end stores.

Software sets the start bit to open a message. This loads the initial chaining values for the selected algorithm. Software then streams the message words and sets the final bit to close the message. On the final request the front-end pads the message in hardware: it appends a marker word and zero fill, then places the 64-bit message length in bits in the last two words, and emits one extra block when the length does not fit. The state window then holds the digest. Software can also write the window to save and restore a partly hashed message. Two request lines let a DMA engine feed blocks in and collect the finished digest.

Top module: `hash_regif`

## Requirements
- R1: After reset, the control word (offset 0x00) and the byte counter (offset 0x04) read 0, and both DMA request outputs are low.
- R2: A control write with bit 0 set while idle makes bit 0 read 1 and loads the initial state for the mode in bits 5:4. Mode 0 loads the SHA-256 values, mode 1 the SHA-224 values, and modes 2 and 3 the five SHA-1 values with words 5 to 7 zero. Setting bit 0 while busy changes no state word.
- R3: While busy and not finalising, a write anywhere in 0x80 to 0xBF appends its data as the next message word, whatever the offset. Word i of a block drives core_block_o[32*i+31:32*i]. Data writes made while idle are discarded and do not count toward the byte counter.
- R4: When 16 words are held, core_start_o pulses for exactly one cycle with that block. Until core_done_i arrives, writes to the data and state windows hold bus_ready_o low. On done, the state words take the values on core_state_i.
- R5: Setting control bit 1 finalises the message. The front-end appends word 0x80000000 after the last message word, fills with zeros, and puts the message bit length in word 14 (upper half) and word 15 (lower half). It adds a separate length block when more than 13 words are already held. Bits 0 and 1 read 1 until the last block is done, then both read 0.
- R6: The byte counter is updated only when finalisation completes, to 4 times the number of message words accepted. Full blocks processed before then leave it unchanged.
- R7: A read at 0x40+4*i returns state word i. With control bit 3 set it is returned as held; with bit 3 clear its four bytes are reversed.
- R8: A write at 0x40+4*i replaces state word i with the written data, whatever the byte order setting.
- R9: Control bits 2, 3, 5:4, 9 and 10 read back as last written. Bits 31:11 and 8:6 always read 0.
- R10: dma_in_req_o is high when bit 2 is set, the engine is busy and not finalising, and no words are held. dma_out_req_o is high when bit 10 is set and a digest is ready; a digest stays ready from the completion of finalisation until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| bus_ready_o | output | 1 | Low while a write must be held |
| core_start_o | output | 1 | One-cycle block start pulse to the core |
| core_mode_o | output | 2 | Algorithm select from control bits 5:4 |
| core_block_o | output | 32*BLK_WORDS | Block words, word i at bits 32*i upward |
| core_state_o | output | 32*STATE_WORDS | Chaining state, word i at bits 32*i upward |
| core_done_i | input | 1 | Core has finished the block |
| core_state_i | input | 32*STATE_WORDS | Updated chaining state, valid with done |
| dma_in_req_o | output | 1 | Input DMA request |
| dma_out_req_o | output | 1 | Output DMA request |

## Verification
The assertions assume that the core raises done only after a start pulse it has accepted, and that the bus drives each write until bus_ready_o allows it. The bench's behavioural core answers each start exactly once, after a fixed three-cycle delay. Its bus tasks hold every write until ready is seen high, so the state checked after a stall is always reached legally. Finalisation is requested only while a message is open, so the final and busy flags never disagree.

// File: rtl/hash_regif_pkg.sv
package hash_regif_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_CORE} seq_st_e;

  localparam int unsigned CB_START   = 0;
  localparam int unsigned CB_FINAL   = 1;
  localparam int unsigned CB_IN_DMA  = 2;
  localparam int unsigned CB_OUT_BE  = 3;
  localparam int unsigned CB_MODE    = 4;
  localparam int unsigned CB_FIFO    = 9;
  localparam int unsigned CB_OUT_DMA = 10;

  localparam logic [31:0] PAD_MARK = 32'h8000_0000;

  function automatic logic [31:0] iv_word(input logic [1:0] mode, input int unsigned idx);
    logic [31:0] v;
    v = '0;
    case (mode)
      2'd0: case (idx)
        0: v = 32'h6a09e667; 1: v = 32'hbb67ae85; 2: v = 32'h3c6ef372; 3: v = 32'ha54ff53a;
        4: v = 32'h510e527f; 5: v = 32'h9b05688c; 6: v = 32'h1f83d9ab; 7: v = 32'h5be0cd19;
        default: v = '0;
      endcase
      2'd1: case (idx)
        0: v = 32'hc1059ed8; 1: v = 32'h367cd507; 2: v = 32'h3070dd17; 3: v = 32'hf70e5939;
        4: v = 32'hffc00b31; 5: v = 32'h68581511; 6: v = 32'h64f98fa7; 7: v = 32'hbefa4fa4;
        default: v = '0;
      endcase
      default: case (idx)
        0: v = 32'h67452301; 1: v = 32'hefcdab89; 2: v = 32'h98badcfe; 3: v = 32'h10325476;
        4: v = 32'hc3d2e1f0;
        default: v = '0;
      endcase
    endcase
    return v;
  endfunction

endpackage

// File: rtl/hash_blk_buf.sv
module hash_blk_buf #(
  parameter int unsigned BLK_WORDS = 16,
  localparam int unsigned CNT_W = $clog2(BLK_WORDS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    push_i,
  input  logic [31:0]             push_data_i,
  input  logic                    pad_mark_i,
  input  logic                    pad_len_i,
  input  logic [31:0]             len_hi_i,
  input  logic [31:0]             len_lo_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    full_o,
  output logic                    room_len_o,
  output logic [32*BLK_WORDS-1:0] block_o
);
  import hash_regif_pkg::*;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLK_WORDS);
  localparam logic [CNT_W-1:0] CNT_ROOM = CNT_W'(BLK_WORDS - 3);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CNT_FULL);
  assign room_len_o = (cnt_q <= CNT_ROOM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (pad_mark_i || pad_len_i) cnt_q <= CNT_FULL;
    else if (push_i)                 cnt_q <= cnt_q + 1'b1;
  end

  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_word
    logic [31:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w_q <= '0;
      end else if (push_i && cnt_q == CNT_W'(j)) begin
        w_q <= push_data_i;
      end else if (pad_mark_i) begin
        if (cnt_q == CNT_W'(j))     w_q <= PAD_MARK;
        else if (CNT_W'(j) > cnt_q) w_q <= '0;
        if (room_len_o && j == BLK_WORDS - 2) w_q <= len_hi_i;
        if (room_len_o && j == BLK_WORDS - 1) w_q <= len_lo_i;
      end else if (pad_len_i) begin
        w_q <= (j == BLK_WORDS - 2) ? len_hi_i :
               (j == BLK_WORDS - 1) ? len_lo_i : '0;
      end
    end
    assign block_o[32*j +: 32] = w_q;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R4
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R4

endmodule

// File: rtl/hash_state_regs.sv
module hash_state_regs #(
  parameter int unsigned STATE_WORDS = 8,
  localparam int unsigned IDX_W = $clog2(STATE_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      iv_load_i,
  input  logic [1:0]                mode_i,
  input  logic                      core_load_i,
  input  logic [32*STATE_WORDS-1:0] core_state_i,
  input  logic                      wr_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [31:0]               wr_data_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  input  logic                      rd_be_i,
  output logic [32*STATE_WORDS-1:0] state_o,
  output logic [31:0]               rd_data_o
);
  import hash_regif_pkg::*;

  logic [31:0] st_q [STATE_WORDS];
  logic [31:0] rd_w;

  for (genvar i = 0; i < STATE_WORDS; i++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 st_q[i] <= '0;
      else if (iv_load_i)                          st_q[i] <= iv_word(mode_i, i);
      else if (core_load_i)                        st_q[i] <= core_state_i[32*i +: 32];
      else if (wr_i && wr_idx_i == IDX_W'(i))      st_q[i] <= wr_data_i;
    end
    assign state_o[32*i +: 32] = st_q[i];
  end

  assign rd_w      = st_q[rd_idx_i];
  assign rd_data_o = rd_be_i ? rd_w : {rd_w[7:0], rd_w[15:8], rd_w[23:16], rd_w[31:24]};

  AST_NO_LOAD_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_load_i |-> !wr_i); // R4

endmodule

// File: rtl/hash_seq.sv
module hash_seq (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_wr_i,
  input  logic [10:0] ctrl_wdata_i,
  input  logic        data_push_i,
  input  logic        full_i,
  input  logic        room_len_i,
  input  logic        core_done_i,
  output logic        busy_o,
  output logic        final_o,
  output logic        fill_o,
  output logic        core_run_o,
  output logic        core_start_o,
  output logic        iv_load_o,
  output logic        buf_clear_o,
  output logic        pad_mark_o,
  output logic        pad_len_o,
  output logic        core_load_o,
  output logic        digest_rdy_o,
  output logic        cfg_in_dma_o,
  output logic        cfg_out_be_o,
  output logic [1:0]  cfg_mode_o,
  output logic        cfg_fifo_o,
  output logic        cfg_out_dma_o,
  output logic [31:0] msg_bytes_o,
  output logic [31:0] bytecnt_o
);
  import hash_regif_pkg::*;

  seq_st_e     st_q;
  logic        final_q, marked_q, last_q, digest_q;
  logic [31:0] msg_q, bytecnt_q;
  logic        start_acc, core_fin;

  assign start_acc    = ctrl_wr_i && ctrl_wdata_i[CB_START] && (st_q == ST_IDLE);
  assign core_fin     = (st_q == ST_CORE) && core_done_i;
  assign core_start_o = (st_q == ST_FILL) && full_i;
  assign pad_mark_o   = (st_q == ST_FILL) && !full_i && final_q && !marked_q;
  assign pad_len_o    = (st_q == ST_FILL) && !full_i && final_q && marked_q && !last_q;
  assign core_load_o  = core_fin;
  assign buf_clear_o  = core_fin || start_acc;
  assign iv_load_o    = start_acc;
  assign busy_o       = (st_q != ST_IDLE);
  assign final_o      = final_q;
  assign fill_o       = (st_q == ST_FILL);
  assign core_run_o   = (st_q == ST_CORE);
  assign digest_rdy_o = digest_q;
  assign msg_bytes_o  = msg_q;
  assign bytecnt_o    = bytecnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start_acc)    st_q <= ST_FILL;
        ST_FILL: if (core_start_o) st_q <= ST_CORE;
        ST_CORE: if (core_done_i)  st_q <= last_q ? ST_IDLE : ST_FILL;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      final_q <= 1'b0; marked_q <= 1'b0; last_q <= 1'b0; digest_q <= 1'b0;
      msg_q <= '0; bytecnt_q <= '0;
    end else begin
      if (core_fin && last_q)
        final_q <= 1'b0;
      else if (ctrl_wr_i && ctrl_wdata_i[CB_FINAL] && (busy_o || start_acc))
        final_q <= 1'b1;

      if (start_acc)       marked_q <= 1'b0;
      else if (pad_mark_o) marked_q <= 1'b1;

      if (start_acc)                      last_q <= 1'b0;
      else if (pad_mark_o && room_len_i)  last_q <= 1'b1;
      else if (pad_len_o)                 last_q <= 1'b1;

      if (start_acc)        msg_q <= '0;
      else if (data_push_i) msg_q <= msg_q + 32'd4;

      if (core_fin && last_q) bytecnt_q <= msg_q;

      if (start_acc)               digest_q <= 1'b0;
      else if (core_fin && last_q) digest_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_in_dma_o <= 1'b0; cfg_out_be_o <= 1'b0; cfg_mode_o <= 2'd0;
      cfg_fifo_o <= 1'b0; cfg_out_dma_o <= 1'b0;
    end else if (ctrl_wr_i) begin
      cfg_in_dma_o  <= ctrl_wdata_i[CB_IN_DMA];
      cfg_out_be_o  <= ctrl_wdata_i[CB_OUT_BE];
      cfg_mode_o    <= ctrl_wdata_i[CB_MODE +: 2];
      cfg_fifo_o    <= ctrl_wdata_i[CB_FIFO];
      cfg_out_dma_o <= ctrl_wdata_i[CB_OUT_DMA];
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o); // R4
  AST_BYTECNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_fin && last_q) |=> $stable(bytecnt_q)); // R6
  AST_FINAL_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_q |-> busy_o); // R5
  AST_NO_PUSH_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_push_i |-> !final_q); // R5

endmodule

// File: rtl/hash_regif.sv
module hash_regif #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BLK_WORDS   = 16,
  parameter int unsigned STATE_WORDS = 8,
  localparam int unsigned IDX_W      = $clog2(STATE_WORDS),
  localparam int unsigned CNT_W      = $clog2(BLK_WORDS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_req_i,
  input  logic                      bus_we_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [31:0]               bus_wdata_i,
  output logic [31:0]               bus_rdata_o,
  output logic                      bus_ready_o,
  output logic                      core_start_o,
  output logic [1:0]                core_mode_o,
  output logic [32*BLK_WORDS-1:0]   core_block_o,
  output logic [32*STATE_WORDS-1:0] core_state_o,
  input  logic                      core_done_i,
  input  logic [32*STATE_WORDS-1:0] core_state_i,
  output logic                      dma_in_req_o,
  output logic                      dma_out_req_o
);
  localparam logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] CNT_OFS   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] HASH_BASE = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] HASH_END  = ADDR_W'(8'h40 + 4 * STATE_WORDS);
  localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] DATA_END  = ADDR_W'(8'h80 + 4 * BLK_WORDS);

  logic is_ctrl, is_cnt, is_hash, is_data;
  logic [ADDR_W-1:0] hash_ofs;
  logic [IDX_W-1:0]  hash_idx;
  logic ctrl_wr, data_push, hash_wr, hold, accepting;

  logic busy, fin, fill, core_run, iv_load, buf_clear, pad_mark, pad_len, core_load, digest_rdy;
  logic cfg_in_dma, cfg_out_be, cfg_fifo, cfg_out_dma;
  logic [1:0] cfg_mode;
  logic [31:0] msg_bytes, bytecnt, hash_rd, ctrl_rd;
  logic [CNT_W-1:0] buf_cnt;
  logic buf_full, room_len;

  assign is_ctrl  = (bus_addr_i[ADDR_W-1:2] == CTRL_OFS[ADDR_W-1:2]);
  assign is_cnt   = (bus_addr_i[ADDR_W-1:2] == CNT_OFS[ADDR_W-1:2]);
  assign is_hash  = (bus_addr_i >= HASH_BASE) && (bus_addr_i < HASH_END);
  assign is_data  = (bus_addr_i >= DATA_BASE) && (bus_addr_i < DATA_END);
  assign hash_ofs = bus_addr_i - HASH_BASE;
  assign hash_idx = hash_ofs[IDX_W+1:2];

  assign accepting = busy && !fin;
  assign hold      = buf_full || core_run;
  assign ctrl_wr   = bus_req_i && bus_we_i && is_ctrl;
  assign data_push = bus_req_i && bus_we_i && is_data && accepting && !hold;
  assign hash_wr   = bus_req_i && bus_we_i && is_hash && !hold;
  assign bus_ready_o = !(bus_req_i && bus_we_i && hold && ((is_data && accepting) || is_hash));

  hash_seq u_seq (
    .clk_i, .rst_ni,
    .ctrl_wr_i    (ctrl_wr),
    .ctrl_wdata_i (bus_wdata_i[10:0]),
    .data_push_i  (data_push),
    .full_i       (buf_full),
    .room_len_i   (room_len),
    .core_done_i,
    .busy_o       (busy),
    .final_o      (fin),
    .fill_o       (fill),
    .core_run_o   (core_run),
    .core_start_o,
    .iv_load_o    (iv_load),
    .buf_clear_o  (buf_clear),
    .pad_mark_o   (pad_mark),
    .pad_len_o    (pad_len),
    .core_load_o  (core_load),
    .digest_rdy_o (digest_rdy),
    .cfg_in_dma_o (cfg_in_dma),
    .cfg_out_be_o (cfg_out_be),
    .cfg_mode_o   (cfg_mode),
    .cfg_fifo_o   (cfg_fifo),
    .cfg_out_dma_o(cfg_out_dma),
    .msg_bytes_o  (msg_bytes),
    .bytecnt_o    (bytecnt)
  );

  hash_blk_buf #(.BLK_WORDS(BLK_WORDS)) u_buf (
    .clk_i, .rst_ni,
    .clear_i     (buf_clear),
    .push_i      (data_push),
    .push_data_i (bus_wdata_i),
    .pad_mark_i  (pad_mark),
    .pad_len_i   (pad_len),
    .len_hi_i    ({29'd0, msg_bytes[31:29]}),
    .len_lo_i    ({msg_bytes[28:0], 3'd0}),
    .cnt_o       (buf_cnt),
    .full_o      (buf_full),
    .room_len_o  (room_len),
    .block_o     (core_block_o)
  );

  hash_state_regs #(.STATE_WORDS(STATE_WORDS)) u_state (
    .clk_i, .rst_ni,
    .iv_load_i    (iv_load),
    .mode_i       (bus_wdata_i[5:4]),
    .core_load_i  (core_load),
    .core_state_i,
    .wr_i         (hash_wr),
    .wr_idx_i     (hash_idx),
    .wr_data_i    (bus_wdata_i),
    .rd_idx_i     (hash_idx),
    .rd_be_i      (cfg_out_be),
    .state_o      (core_state_o),
    .rd_data_o    (hash_rd)
  );

  assign core_mode_o   = cfg_mode;
  assign ctrl_rd       = {21'd0, cfg_out_dma, cfg_fifo, 3'd0, cfg_mode, cfg_out_be, cfg_in_dma, fin, busy};
  assign dma_in_req_o  = cfg_in_dma && fill && !fin && (buf_cnt == '0);
  assign dma_out_req_o = cfg_out_dma && digest_rdy;

  always_comb begin
    bus_rdata_o = '0;
    if (is_ctrl)      bus_rdata_o = ctrl_rd;
    else if (is_cnt)  bus_rdata_o = bytecnt;
    else if (is_hash) bus_rdata_o = hash_rd;
  end

  AST_PUSH_IN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_push |-> fill); // R3
  AST_OUT_DMA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_out_req_o |-> !busy); // R10
  AST_IN_DMA_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_in_req_o |-> (busy && !core_start_o)); // R10

endmodule

// File: tb/hash_regif_tb.sv
module hash_regif_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        ready, core_start, core_done, dma_in, dma_out;
  logic [1:0]  core_mode;
  logic [511:0] core_block;
  logic [255:0] core_state_o, core_state_i;

  hash_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ready_o(ready),
    .core_start_o(core_start), .core_mode_o(core_mode), .core_block_o(core_block),
    .core_state_o(core_state_o), .core_done_i(core_done), .core_state_i(core_state_i),
    .dma_in_req_o(dma_in), .dma_out_req_o(dma_out)
  );

  int checks = 0, fails = 0, start_cnt = 0, cs_cnt = 0;
  logic [511:0] cs_blk;
  logic [255:0] cs_st;
  logic [31:0] exp_st [8];

  function automatic logic [31:0] rot16(input logic [31:0] x);
    return {x[15:0], x[31:16]};
  endfunction

  // behavioural core stand-in: three-cycle latency
  always_ff @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      cs_blk <= core_block; cs_st <= core_state_o; cs_cnt <= 3; start_cnt <= start_cnt + 1;
    end else if (cs_cnt > 1) begin
      cs_cnt <= cs_cnt - 1;
    end else if (cs_cnt == 1) begin
      cs_cnt <= 0; core_done <= 1'b1;
      for (int i = 0; i < 8; i++)
        core_state_i[32*i +: 32] <= cs_st[32*i +: 32] +
          (cs_blk[32*i +: 32] ^ rot16(cs_blk[32*(i+8) +: 32])) + 32'(i);
    end
  end

  function automatic logic [31:0] tb_iv(input logic [1:0] m, input int i);
    logic [31:0] a [8];
    if (m == 2'd0) a = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                         32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    else if (m == 2'd1) a = '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                              32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
    else a = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
               32'hc3d2e1f0, 32'h0, 32'h0, 32'h0};
    return a[i];
  endfunction

  function automatic logic [31:0] msg_word(input logic [31:0] seed, input int k);
    return seed ^ (32'(k) * 32'h9e3779b9);
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic model_msg(input int nw, input logic [31:0] seed);
    logic [31:0] pw [48];
    int p;
    logic [31:0] nb;
    p = ((nw + 3 + 15) / 16) * 16;
    nb = 32'(nw) * 32'd4;
    for (int k = 0; k < p; k++) begin
      if (k < nw)        pw[k] = msg_word(seed, k);
      else if (k == nw)  pw[k] = 32'h8000_0000;
      else if (k == p-2) pw[k] = {29'd0, nb[31:29]};
      else if (k == p-1) pw[k] = {nb[28:0], 3'd0};
      else               pw[k] = 32'd0;
    end
    for (int b = 0; b < p / 16; b++)
      for (int i = 0; i < 8; i++)
        exp_st[i] = exp_st[i] + (pw[b*16+i] ^ rot16(pw[b*16+i+8])) + 32'(i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    d = 32'h1;
    for (int i = 0; i < 300; i++) begin
      rd(8'h00, d);
      if (!d[0]) break;
    end
    chk(tag, {31'd0, d[0]}, 32'd0);
  endtask

  task automatic chk_digest(input logic be, input string tag);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'h40 + 8'(4*i), d);
      chk(tag, d, be ? exp_st[i] : bswap(exp_st[i]));
    end
  endtask

  // {mode[40:39], be[38], nwords[37:32], seed[31:0]}
  localparam logic [40:0] CASES [7] = '{
    {2'd0, 1'b1, 6'd3,  32'h1111_0001},
    {2'd1, 1'b0, 6'd13, 32'h2222_0002},
    {2'd2, 1'b1, 6'd14, 32'h3333_0003},
    {2'd3, 1'b0, 6'd15, 32'h4444_0004},
    {2'd0, 1'b0, 6'd16, 32'h5555_0005},
    {2'd1, 1'b1, 6'd20, 32'h6666_0006},
    {2'd0, 1'b1, 6'd0,  32'h7777_0007}
  };

  bit finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int sc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h04, d); chk("R1 bytecnt", d, 32'h0);
    chk("R1 dma_in", {31'd0, dma_in}, 32'd0);
    chk("R1 dma_out", {31'd0, dma_out}, 32'd0);

    // R9 unassigned bits
    wr(8'h00, 32'hFFFF_FFFC);
    rd(8'h00, d); chk("R9 ctrl readback", d, 32'h0000_063C);
    wr(8'h00, 32'h0);

    // R2 R8 R4 R6 R5 R10: mode 1, big-endian, both DMA enables
    wr(8'h00, 32'h0000_041D);
    rd(8'h00, d); chk("R2 busy", d, 32'h0000_041D);
    chk("R10 dma_in open", {31'd0, dma_in}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      rd(8'h40 + 8'(4*i), d); chk("R2 iv224", d, tb_iv(2'd1, i));
    end
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, d); chk("R8 state write", d, 32'hDEAD_BEEF);
    wr(8'h00, 32'h0000_041D);
    rd(8'h40, d); chk("R2 start ignored w0", d, 32'hDEAD_BEEF);
    rd(8'h44, d); chk("R2 start ignored w1", d, tb_iv(2'd1, 1));
    sc = start_cnt;
    for (int k = 0; k < 16; k++) wr(8'h80 + 8'(((k*7) % 16) * 4), msg_word(32'hABCD_0000, k));
    @(negedge clk); req = 1; we = 1; addr = 8'h80; wdata = 32'h0; #1;
    chk("R4 stall", {31'd0, ready}, 32'd0);
    req = 0; we = 0;
    repeat (12) @(posedge clk);
    chk("R4 one start", 32'(start_cnt - sc), 32'd1);
    rd(8'h04, d); chk("R6 hold", d, 32'h0);
    wr(8'h00, 32'h0000_041E);
    rd(8'h00, d); chk("R5 final busy", d, 32'h0000_041F);
    wait_idle("R5 idle");
    rd(8'h00, d); chk("R5 ctrl clear", d, 32'h0000_041C);
    rd(8'h04, d); chk("R6 bytecnt", d, 32'd64);
    for (int i = 0; i < 8; i++) exp_st[i] = tb_iv(2'd1, i);
    exp_st[0] = 32'hDEAD_BEEF;
    model_msg(16, 32'hABCD_0000);
    chk_digest(1'b1, "R5 R8 digest");
    chk("R10 dma_out", {31'd0, dma_out}, 32'd1);
    chk("R10 dma_in idle", {31'd0, dma_in}, 32'd0);

    // R3 idle writes dropped
    for (int k = 0; k < 3; k++) wr(8'h84, 32'h5A5A_0000 + 32'(k));
    wr(8'h00, 32'h0000_0001);
    wr(8'h00, 32'h0000_0002);
    wait_idle("R3 idle");
    rd(8'h04, d); chk("R3 bytecnt", d, 32'd0);
    for (int i = 0; i < 8; i++) exp_st[i] = tb_iv(2'd0, i);
    model_msg(0, 32'h0);
    chk_digest(1'b0, "R3 R7 digest");
    chk("R10 dma_out off", {31'd0, dma_out}, 32'd0);

    // vector table: modes, byte orders, padding boundaries
    for (int c = 0; c < 7; c++) begin
      logic [1:0] m; logic be; int nw; logic [31:0] seed; logic [31:0] cfg;
      m = CASES[c][40:39]; be = CASES[c][38]; nw = int'(CASES[c][37:32]); seed = CASES[c][31:0];
      cfg = {28'd0, m, be, 2'b00} & 32'h3F;
      cfg = {26'd0, m, be, 3'b000};
      wr(8'h00, cfg | 32'h1);
      for (int k = 0; k < nw; k++) wr(8'h80 + 8'(((k*5 + c) % 16) * 4), msg_word(seed, k));
      wr(8'h00, cfg | 32'h2);
      wait_idle("R5 table idle");
      rd(8'h04, d); chk("R6 table bytecnt", d, 32'(nw * 4));
      for (int i = 0; i < 8; i++) exp_st[i] = tb_iv(m, i);
      model_msg(nw, seed);
      chk_digest(be, "R3 R4 R5 R7 table digest");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule